// File: doc/BRIEF.md
# Half-Bridge PWM Phase Channel with Shadowed Settings and Failsafe

This block drives one phase of a three-phase motor power stage. A period counter shared by every phase, together with its end-of-period pulse, comes from outside. Each cycle the channel compares that count with its active match word. The result is a high-side gate command, `hi_gate`. A second output, `bridge_en`, is a bridge-enable level. When `bridge_en` is low, both transistors of the half-bridge are held off.

The match word and the two enable bits are first written to staging inputs. The channel copies them into its active registers only on the clock edge that closes a period, and only when the writer marks the staged set as consistent. A value written part-way through a period therefore changes nothing until the next period starts. If the staged set is not marked consistent, the previous settings carry over for another period.

A `failsafe` input clears both outputs at once, with no clock edge needed. It also wipes the active settings. After `failsafe` is released, the stage stays off until a fresh consistent set is committed. Both outputs are registered, so they lag the counter by one cycle.

Top module: `pwm_phase_channel`

## Requirements
- R1: While `rst` is high at a rising clock edge, both outputs are 0 after that edge and the active settings return to disabled (match 0, both enables 0).
- R2: In the cycle after the counter shows value k, `hi_gate` equals 1 exactly when the active high-side enable is 1 and k is strictly less than the active match word. This holds when no failsafe or reset is applied.
- R3: The active match word sets the duty cycle. A match of 0 gives no high ticks in a period. A match of 2^CNT_W-1 gives 2^CNT_W-1 high ticks out of 2^CNT_W.
- R4: In the cycle after any counter value, `bridge_en` equals the active bridge enable. It is therefore either high or low for a whole period.
- R5: The active settings take the staged values only at a rising edge where both `wrap` and `stage_valid` are 1. `wrap` is high during the last count of the period. Staged changes made earlier in a period do not alter the outputs for the rest of that period.
- R6: At a rising edge where `wrap` is 1 and `stage_valid` is 0, the active settings are kept. The following period repeats the previous duty cycle and bridge level.
- R7: A 1 on `failsafe` forces `hi_gate` and `bridge_en` to 0 without waiting for a clock edge. The outputs stay at 0 for as long as `failsafe` is high, whatever the enables and the match word are.
- R8: When `failsafe` is released, the active settings are disabled. Both outputs stay 0 until a commit under R5 loads new enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| failsafe | input | 1 | Asynchronous power-stage kill |
| cnt | input | CNT_W | Shared period count, running from 0 to 2^CNT_W-1 |
| wrap | input | 1 | High during the last count of a period |
| stage_valid | input | 1 | Marks that the staged set is consistent |
| stage_hi_en | input | 1 | Staged high-side enable |
| stage_br_en | input | 1 | Staged bridge enable |
| stage_match | input | CNT_W | Staged match word |
| hi_gate | output | 1 | High-side gate command |
| bridge_en | output | 1 | Half-bridge enable; low holds both transistors off |

## Verification
The bench walks a sequence of settings and counts high ticks over whole periods. This covers match 0, match 1, the top match and disabled enables. An off-by-one comparison would give one tick too many or too few, and a reversed polarity would give the complement count. Each new set is written in the middle of a period. The bench then compares every cycle of that period with a model that still uses the old settings, so a design that loads early shows a mismatch before the wrap. A period that ends with `stage_valid` low must repeat the old duty cycle; a design that commits anyway would show the new duty cycle instead. Failsafe is raised mid-period and the outputs are sampled before any clock edge, which catches a synchronous-only kill. After release, the bench checks that the old settings do not come back on their own.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
  localparam int unsigned DEF_CNT_W = 11;

  typedef struct packed {
    logic hi_en;
    logic br_en;
  } en_pair_t;

  localparam en_pair_t EN_OFF = '{hi_en: 1'b0, br_en: 1'b0};
endpackage

// File: rtl/pwmc_shadow.sv
module pwmc_shadow
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             commit,
  input  en_pair_t         stage_en,
  input  logic [CNT_W-1:0] stage_match,
  output en_pair_t         act_en,
  output logic [CNT_W-1:0] act_match
);
  always_ff @(posedge clk or posedge kill) begin
    if (kill) begin
      act_en    <= EN_OFF;
      act_match <= '0;
    end else if (rst) begin
      act_en    <= EN_OFF;
      act_match <= '0;
    end else if (commit) begin
      act_en    <= stage_en;
      act_match <= stage_match;
    end
  end
endmodule

// File: rtl/pwmc_compare.sv
module pwmc_compare
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] match,
  input  en_pair_t         en,
  output logic             hi_next,
  output logic             br_next
);
  logic below;

  always_comb begin
    below   = (cnt < match);
    hi_next = en.hi_en & below;
    br_next = en.br_en;
  end
endmodule

// File: rtl/pwmc_outstage.sv
module pwmc_outstage (
  input  logic clk,
  input  logic rst,
  input  logic kill,
  input  logic hi_next,
  input  logic br_next,
  output logic hi_q,
  output logic br_q
);
  always_ff @(posedge clk or posedge kill) begin
    if (kill) begin
      hi_q <= 1'b0;
      br_q <= 1'b0;
    end else if (rst) begin
      hi_q <= 1'b0;
      br_q <= 1'b0;
    end else begin
      hi_q <= hi_next;
      br_q <= br_next;
    end
  end
endmodule

// File: rtl/pwm_phase_channel.sv
module pwm_phase_channel
  import pwmc_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             failsafe,
  input  logic [CNT_W-1:0] cnt,
  input  logic             wrap,
  input  logic             stage_valid,
  input  logic             stage_hi_en,
  input  logic             stage_br_en,
  input  logic [CNT_W-1:0] stage_match,
  output logic             hi_gate,
  output logic             bridge_en
);
  en_pair_t         stage_en;
  en_pair_t         act_en;
  logic [CNT_W-1:0] act_match;
  logic             commit;
  logic             hi_next;
  logic             br_next;

  assign stage_en = '{hi_en: stage_hi_en, br_en: stage_br_en};
  assign commit   = wrap & stage_valid;

  pwmc_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk         (clk),
    .rst         (rst),
    .kill        (failsafe),
    .commit      (commit),
    .stage_en    (stage_en),
    .stage_match (stage_match),
    .act_en      (act_en),
    .act_match   (act_match)
  );

  pwmc_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt     (cnt),
    .match   (act_match),
    .en      (act_en),
    .hi_next (hi_next),
    .br_next (br_next)
  );

  pwmc_outstage u_out (
    .clk     (clk),
    .rst     (rst),
    .kill    (failsafe),
    .hi_next (hi_next),
    .br_next (br_next),
    .hi_q    (hi_gate),
    .br_q    (bridge_en)
  );
endmodule

// File: rtl/pwm_phase_channel_chk.sv
module pwm_phase_channel_chk #(
  parameter int unsigned CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             failsafe,
  input logic [CNT_W-1:0] cnt,
  input logic             wrap,
  input logic             stage_valid,
  input logic [CNT_W-1:0] stage_match,
  input logic [CNT_W-1:0] act_match,
  input logic             act_hi,
  input logic             act_br,
  input logic             hi_gate,
  input logic             bridge_en
);
  // R1
  reset_off_chk: assert property (@(posedge clk) disable iff (failsafe)
    rst |=> (!hi_gate && !bridge_en && !act_hi && !act_br));

  // R7
  failsafe_off_chk: assert property (@(posedge clk) disable iff (rst)
    failsafe |-> (!hi_gate && !bridge_en));

  // R2
  past_match_low_chk: assert property (@(posedge clk) disable iff (rst || failsafe)
    (cnt >= act_match) |=> !hi_gate);

  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (rst || failsafe)
    (wrap && stage_valid) |=> (act_match == $past(stage_match)));

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst || failsafe)
    !(wrap && stage_valid) |=> ($stable(act_match) && $stable(act_hi) && $stable(act_br)));
endmodule

bind pwm_phase_channel pwm_phase_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .failsafe    (failsafe),
  .cnt         (cnt),
  .wrap        (wrap),
  .stage_valid (stage_valid),
  .stage_match (stage_match),
  .act_match   (act_match),
  .act_hi      (act_en.hi_en),
  .act_br      (act_en.br_en),
  .hi_gate     (hi_gate),
  .bridge_en   (bridge_en)
);

// File: tb/pwm_phase_channel_bench.sv
module pwm_phase_channel_bench;
  localparam int W    = 11;
  localparam int MAXC = (1 << W) - 1;
  localparam int PER  = 1 << W;

  typedef struct packed {
    int match;
    bit hi;
    bit br;
    bit vld;
    int exp_hi;
    int exp_br;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{match: 1000, hi: 1'b1, br: 1'b1, vld: 1'b1, exp_hi: 1000, exp_br: PER},
    '{match: 0,    hi: 1'b1, br: 1'b1, vld: 1'b1, exp_hi: 0,    exp_br: PER},
    '{match: MAXC, hi: 1'b1, br: 1'b1, vld: 1'b1, exp_hi: MAXC, exp_br: PER},
    '{match: 500,  hi: 1'b1, br: 1'b0, vld: 1'b0, exp_hi: MAXC, exp_br: PER},
    '{match: 1,    hi: 1'b1, br: 1'b0, vld: 1'b1, exp_hi: 1,    exp_br: 0},
    '{match: 1500, hi: 1'b0, br: 1'b1, vld: 1'b1, exp_hi: 0,    exp_br: PER},
    '{match: 300,  hi: 1'b1, br: 1'b1, vld: 1'b1, exp_hi: 300,  exp_br: PER}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         failsafe = 1'b0;
  logic [W-1:0] cnt = '0;
  logic         wrap = 1'b0;
  logic         stage_valid = 1'b0;
  logic         stage_hi_en = 1'b0;
  logic         stage_br_en = 1'b0;
  logic [W-1:0] stage_match = '0;
  logic         hi_gate;
  logic         bridge_en;

  int n_checks = 0;
  int n_fail   = 0;
  int mism     = 0;
  int hi_cnt   = 0;
  int br_cnt   = 0;
  int last_cnt = 0;
  bit m_hi = 0;
  bit m_br = 0;
  int m_match = 0;

  always #5 clk = ~clk;

  pwm_phase_channel #(.CNT_W(W)) u_pwm_phase_channel (
    .clk         (clk),
    .rst         (rst),
    .failsafe    (failsafe),
    .cnt         (cnt),
    .wrap        (wrap),
    .stage_valid (stage_valid),
    .stage_hi_en (stage_hi_en),
    .stage_br_en (stage_br_en),
    .stage_match (stage_match),
    .hi_gate     (hi_gate),
    .bridge_en   (bridge_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock: compare outputs for the count the design just registered,
  // update the model, then present the next count.
  task automatic tick();
    bit e_hi;
    bit e_br;
    @(negedge clk);
    if (rst || failsafe) begin
      m_hi = 0; m_br = 0; m_match = 0;
      e_hi = 0; e_br = 0;
    end else begin
      e_hi = m_hi && (int'(cnt) < m_match);
      e_br = m_br;
      if (wrap && stage_valid) begin
        m_hi = stage_hi_en; m_br = stage_br_en; m_match = int'(stage_match);
      end
    end
    if (hi_gate !== e_hi || bridge_en !== e_br) mism++;
    if (hi_gate === 1'b1) hi_cnt++;
    if (bridge_en === 1'b1) br_cnt++;
    last_cnt = int'(cnt);
    cnt  = (int'(cnt) == MAXC) ? '0 : cnt + 1'b1;
    wrap = (int'(cnt) == MAXC);
  endtask

  task automatic run_to(input int v);
    do tick(); while (last_cnt != v);
  endtask

  initial begin
    #(10 * 200000);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int m0;
    repeat (3) tick();
    // R1: reset state
    check("R1 reset hi_gate", int'(hi_gate), 0);
    check("R1 reset bridge_en", int'(bridge_en), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      run_to(1000);
      // R5: staged mid-period, must not touch the current period
      stage_match = W'(VECS[i].match);
      stage_hi_en = VECS[i].hi;
      stage_br_en = VECS[i].br;
      stage_valid = VECS[i].vld;
      m0 = mism;
      run_to(MAXC);
      check("R5 no early load", mism, m0);
      hi_cnt = 0; br_cnt = 0; m0 = mism;
      run_to(MAXC);
      // R2 R3 R6: high ticks over one period
      check("R2/R3/R6 duty ticks", hi_cnt, VECS[i].exp_hi);
      // R4 R6: bridge level over one period
      check("R4/R6 bridge ticks", br_cnt, VECS[i].exp_br);
      check("R2 per-cycle model", mism, m0);
    end

    // R2: mid-period sample with match 300
    run_to(100);
    check("R2 hi mid-period", int'(hi_gate), 1);
    // R7: failsafe acts with no clock edge
    #1 failsafe = 1'b1;
    #1;
    check("R7 hi_gate off at once", int'(hi_gate), 0);
    check("R7 bridge_en off at once", int'(bridge_en), 0);
    m0 = mism;
    repeat (50) tick();
    check("R7 held off", mism, m0);
    failsafe = 1'b0;
    stage_valid = 1'b0;
    hi_cnt = 0; br_cnt = 0;
    run_to(MAXC);
    run_to(MAXC);
    // R8: no return of old settings without a commit
    check("R8 hi stays off", hi_cnt, 0);
    check("R8 bridge stays off", br_cnt, 0);
    stage_valid = 1'b1;
    run_to(MAXC);
    hi_cnt = 0;
    run_to(MAXC);
    check("R8 recommit duty", hi_cnt, 300);

    // R1: reset mid-period
    run_to(50);
    rst = 1'b1;
    tick();
    check("R1 mid reset hi_gate", int'(hi_gate), 0);
    check("R1 mid reset bridge_en", int'(bridge_en), 0);
    rst = 1'b0;
    stage_valid = 1'b0;
    m0 = mism;
    run_to(MAXC);
    run_to(MAXC);
    check("R1 settings cleared", mism, m0);
    check("R1 bridge after reset", int'(bridge_en), 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule